// File: doc/BRIEF.md
# Program Fetch Strobe Generator

This block sits between the instruction sequencer and the program-memory pads of a small microcontroller core. For every instruction fetch it chooses between the on-chip code store and an off-chip code device. When the fetch goes off-chip, it drives an active-low read strobe toward that device.

A free-running tick counter paces the strobe. The counter steps through one machine cycle of twelve oscillator periods, arranged as six states of two phases each. Tick numbering is `tick = (state-1)*2 + (phase-1)`, so state 1 phase 1 is tick 0 and state 6 phase 2 is tick 11. The strobe can open two low windows per machine cycle. The first is low on ticks 5 and 6. The second is low on ticks 10 and 11 and on tick 0 of the following cycle.

Whether a window opens is decided on the clock edge that enters its first tick, so on the edges that leave tick 4 and tick 9. A window opens only if all of these hold at that edge: a fetch is requested, the on-chip store is not selected, and the current machine cycle is not an off-chip data access.

The on-chip store is selected only when two things hold. The external-access level captured at the end of reset must be high, and the program counter must be at or below the on-chip limit (default 3FFFh). The external-access input is sampled once, on the first clock edge after reset is released, and is ignored from then on.

Inside the block, the strobe is produced by a four-state machine whose states are:

- STB_RESET: the state held during reset.
- STB_IDLE: strobe high.
- STB_PULSE_A: the first window is open.
- STB_PULSE_B: the second window is open.

Its transitions are:

- STB_RESET to STB_IDLE, always, on the first edge after reset.
- STB_IDLE to STB_PULSE_A when the first window opens and the opening conditions hold.
- STB_IDLE to STB_PULSE_B when the second window opens and the opening conditions hold.
- STB_PULSE_A back to STB_IDLE when its window closes or the fetch request is dropped.
- STB_PULSE_B back to STB_IDLE when its window closes or the fetch request is dropped.

The strobe comes straight from a flip-flop, so it carries no decode glitches.

Top module: `pfetch_strobe_gen`

## Requirements
- R1: `phase_idx` is 0 during reset. After reset it advances by one on every clock edge and wraps from 11 to 0.
- R2: `fetch_rd_n` is 1 throughout reset. It is also 1 on every edge that follows an edge at which `fetch_req` was 0.
- R3: With an off-chip fetch and no data access, `fetch_rd_n` is 0 exactly on ticks 5, 6, 10, 11 and on tick 0 of the next cycle, and 1 on every other tick.
- R4: If `xdata_cyc` is 1 at the opening edge of a window (the edge leaving tick 4 or tick 9), that window stays high. With `xdata_cyc` held for a whole cycle, neither pulse appears.
- R5: While `code_int_sel` is 1, no window opens and `fetch_rd_n` stays 1.
- R6: With the captured external-access level high, `code_int_sel` is 1 for `pc` at or below 3FFFh and 0 for `pc` at 4000h and above. Off-chip pulses appear in the latter case.
- R7: With the captured external-access level low, `code_int_sel` is 0 for any `pc`, including 0000h, and both pulses appear.
- R8: `ext_code_en` is captured on the first clock edge after reset is released. Later changes have no effect on `code_int_sel`.
- R9: Dropping `fetch_req` while a window is low returns `fetch_rd_n` to 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_code_en | input | 1 | External-access level; high allows the on-chip code store |
| pc | input | PC_W | Current program counter |
| fetch_req | input | 1 | An instruction fetch is in progress |
| xdata_cyc | input | 1 | The current machine cycle accesses off-chip data memory |
| fetch_rd_n | output | 1 | Active-low off-chip code read strobe, registered |
| code_int_sel | output | 1 | 1 when the fetch is served by the on-chip store |
| phase_idx | output | TW | Current tick within the machine cycle, 0 to 11 |

## Verification
Two functions can act in the same cycle. The window-opening decision can coincide with a data-access cycle, and an open window can coincide with the fetch request being withdrawn. The bench provokes the first by raising `xdata_cyc` across a whole machine cycle, and across only the second opening edge. It checks the strobe tick by tick, so a suppressed pulse and a surviving pulse are told apart. It provokes the second by dropping `fetch_req` at the tick where the first pulse is already low. The strobe must be high by the next tick, ahead of the window's normal close.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        STB_RESET   = 2'd0,
        STB_IDLE    = 2'd1,
        STB_PULSE_A = 2'd2,
        STB_PULSE_B = 2'd3
    } stb_state_t;

    // Map a 1-based state and 1-based phase to a tick index.
    function automatic int tick_of(input int st, input int ph, input int phases);
        return (st - 1) * phases + (ph - 1);
    endfunction

endpackage

// File: rtl/pfs_cycle_seq.sv
module pfs_cycle_seq #(
    parameter int TICKS = 12,
    localparam int TW = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick_q,
    output logic [TW-1:0] tick_nxt
);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    always_comb begin
        if (tick_q == LAST) begin
            tick_nxt = '0;
        end else begin
            tick_nxt = tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_nxt;
        end
    end

endmodule

// File: rtl/pfs_window_dec.sv
module pfs_window_dec #(
    parameter int TICKS   = 12,
    parameter int A_OPEN  = 5,
    parameter int A_CLOSE = 7,
    parameter int B_OPEN  = 10,
    parameter int B_CLOSE = 1,
    localparam int TW = $clog2(TICKS)
) (
    input  logic [TW-1:0] tick_nxt,
    output logic          open_a,
    output logic          close_a,
    output logic          open_b,
    output logic          close_b
);
    localparam logic [TW-1:0] A_OPEN_T  = TW'(A_OPEN);
    localparam logic [TW-1:0] A_CLOSE_T = TW'(A_CLOSE);
    localparam logic [TW-1:0] B_OPEN_T  = TW'(B_OPEN);
    localparam logic [TW-1:0] B_CLOSE_T = TW'(B_CLOSE);

    always_comb begin
        open_a  = (tick_nxt == A_OPEN_T);
        close_a = (tick_nxt == A_CLOSE_T);
        open_b  = (tick_nxt == B_OPEN_T);
        close_b = (tick_nxt == B_CLOSE_T);
    end

endmodule

// File: rtl/pfs_mem_select.sv
module pfs_mem_select #(
    parameter int                PC_W      = 16,
    parameter logic [PC_W-1:0]   INT_LIMIT = 16'h3FFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_code_en,
    input  logic [PC_W-1:0] pc,
    output logic            code_int_sel
);
    logic run_q;
    logic ea_q;

    // The level is taken on the first edge out of reset, then frozen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ea_q  <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (!run_q) begin
                ea_q <= ext_code_en;
            end
        end
    end

    always_comb begin
        code_int_sel = ea_q && (pc <= INT_LIMIT);
    end

endmodule

// File: rtl/pfs_strobe_fsm.sv
module pfs_strobe_fsm
    import pfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_req,
    input  logic go_ok,
    input  logic open_a,
    input  logic close_a,
    input  logic open_b,
    input  logic close_b,
    output logic fetch_rd_n
);
    stb_state_t state_q;
    stb_state_t state_nxt;
    logic       rd_n_q;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            STB_RESET: begin
                state_nxt = STB_IDLE;
            end
            STB_IDLE: begin
                if (open_a && go_ok) begin
                    state_nxt = STB_PULSE_A;
                end else if (open_b && go_ok) begin
                    state_nxt = STB_PULSE_B;
                end
            end
            STB_PULSE_A: begin
                if (!fetch_req || close_a) begin
                    state_nxt = STB_IDLE;
                end
            end
            STB_PULSE_B: begin
                if (!fetch_req || close_b) begin
                    state_nxt = STB_IDLE;
                end
            end
            default: begin
                state_nxt = STB_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STB_RESET;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Output register: the strobe comes straight from a flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_n_q <= 1'b1;
        end else begin
            rd_n_q <= !((state_nxt == STB_PULSE_A) || (state_nxt == STB_PULSE_B));
        end
    end

    assign fetch_rd_n = rd_n_q;

endmodule

// File: rtl/pfetch_strobe_gen.sv
module pfetch_strobe_gen #(
    parameter int              PC_W      = 16,
    parameter logic [PC_W-1:0] INT_LIMIT = 16'h3FFF,
    parameter int              STATES    = 6,
    parameter int              PHASES    = 2,
    parameter int              A_OPEN_S  = 3,
    parameter int              A_OPEN_P  = 2,
    parameter int              A_CLOSE_S = 4,
    parameter int              A_CLOSE_P = 2,
    parameter int              B_OPEN_S  = 6,
    parameter int              B_OPEN_P  = 1,
    parameter int              B_CLOSE_S = 1,
    parameter int              B_CLOSE_P = 2,
    localparam int             TICKS     = STATES * PHASES,
    localparam int             TW        = $clog2(TICKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_code_en,
    input  logic [PC_W-1:0] pc,
    input  logic            fetch_req,
    input  logic            xdata_cyc,
    output logic            fetch_rd_n,
    output logic            code_int_sel,
    output logic [TW-1:0]   phase_idx
);
    localparam int A_OPEN  = pfs_pkg::tick_of(A_OPEN_S,  A_OPEN_P,  PHASES);
    localparam int A_CLOSE = pfs_pkg::tick_of(A_CLOSE_S, A_CLOSE_P, PHASES);
    localparam int B_OPEN  = pfs_pkg::tick_of(B_OPEN_S,  B_OPEN_P,  PHASES);
    localparam int B_CLOSE = pfs_pkg::tick_of(B_CLOSE_S, B_CLOSE_P, PHASES);

    logic [TW-1:0] tick_q;
    logic [TW-1:0] tick_nxt;
    logic          open_a;
    logic          close_a;
    logic          open_b;
    logic          close_b;
    logic          int_sel;
    logic          go_ok;

    pfs_cycle_seq #(.TICKS(TICKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_q   (tick_q),
        .tick_nxt (tick_nxt)
    );

    pfs_window_dec #(
        .TICKS   (TICKS),
        .A_OPEN  (A_OPEN),
        .A_CLOSE (A_CLOSE),
        .B_OPEN  (B_OPEN),
        .B_CLOSE (B_CLOSE)
    ) u_win (
        .tick_nxt (tick_nxt),
        .open_a   (open_a),
        .close_a  (close_a),
        .open_b   (open_b),
        .close_b  (close_b)
    );

    pfs_mem_select #(.PC_W(PC_W), .INT_LIMIT(INT_LIMIT)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_code_en  (ext_code_en),
        .pc           (pc),
        .code_int_sel (int_sel)
    );

    always_comb begin
        go_ok = fetch_req && !int_sel && !xdata_cyc;
    end

    pfs_strobe_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .go_ok      (go_ok),
        .open_a     (open_a),
        .close_a    (close_a),
        .open_b     (open_b),
        .close_b    (close_b),
        .fetch_rd_n (fetch_rd_n)
    );

    assign code_int_sel = int_sel;
    assign phase_idx    = tick_q;

endmodule

// File: rtl/pfs_strobe_chk.sv
module pfs_strobe_chk #(
    parameter int              PC_W      = 16,
    parameter logic [PC_W-1:0] INT_LIMIT = 16'h3FFF,
    parameter int              TICKS     = 12,
    parameter int              A_OPEN    = 5,
    parameter int              A_CLOSE   = 7,
    parameter int              B_OPEN    = 10,
    parameter int              B_CLOSE   = 1,
    localparam int             TW        = $clog2(TICKS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc,
    input logic            fetch_req,
    input logic            xdata_cyc,
    input logic            fetch_rd_n,
    input logic            code_int_sel,
    input logic [TW-1:0]   phase_idx
);
    localparam logic [TW-1:0] LAST   = TW'(TICKS - 1);
    localparam logic [TW-1:0] PRE_A  = TW'(A_OPEN - 1);
    localparam logic [TW-1:0] PRE_B  = TW'(B_OPEN - 1);

    logic start_edge;
    logic in_win;

    always_comb begin
        start_edge = (phase_idx == PRE_A) || (phase_idx == PRE_B);
        in_win = ((phase_idx >= TW'(A_OPEN)) && (phase_idx < TW'(A_CLOSE)))
              || (phase_idx >= TW'(B_OPEN)) || (phase_idx < TW'(B_CLOSE));
    end

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_idx == LAST) |=> (phase_idx == '0));

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_idx != LAST) |=> (phase_idx == TW'($past(phase_idx) + 1'b1)));

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> fetch_rd_n);

    a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_rd_n |-> in_win);

    a_r4_data_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (xdata_cyc && start_edge) |=> fetch_rd_n);

    a_r5_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (code_int_sel && start_edge) |=> fetch_rd_n);

    a_r6_limit: assert property (@(posedge clk) disable iff (!rst_n)
        code_int_sel |-> (pc <= INT_LIMIT));

endmodule

bind pfetch_strobe_gen pfs_strobe_chk #(
    .PC_W      (PC_W),
    .INT_LIMIT (INT_LIMIT),
    .TICKS     (TICKS),
    .A_OPEN    (A_OPEN),
    .A_CLOSE   (A_CLOSE),
    .B_OPEN    (B_OPEN),
    .B_CLOSE   (B_CLOSE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc           (pc),
    .fetch_req    (fetch_req),
    .xdata_cyc    (xdata_cyc),
    .fetch_rd_n   (fetch_rd_n),
    .code_int_sel (code_int_sel),
    .phase_idx    (phase_idx)
);

// File: tb/pfetch_strobe_gen_test.sv
module pfetch_strobe_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_code_en = 1'b1;
    logic [15:0] pc = 16'h0000;
    logic        fetch_req = 1'b0;
    logic        xdata_cyc = 1'b0;
    logic        fetch_rd_n;
    logic        code_int_sel;
    logic [3:0]  phase_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pfetch_strobe_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_code_en  (ext_code_en),
        .pc           (pc),
        .fetch_req    (fetch_req),
        .xdata_cyc    (xdata_cyc),
        .fetch_rd_n   (fetch_rd_n),
        .code_int_sel (code_int_sel),
        .phase_idx    (phase_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input bit ea);
        @(negedge clk);
        rst_n = 1'b0;
        ext_code_en = ea;
        repeat (3) @(negedge clk);
        check(fetch_rd_n == 1'b1, "R2 strobe in reset", fetch_rd_n, 1);
        check(phase_idx == 4'd0, "R1 index in reset", phase_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic align_to(input int t);
        for (int k = 0; k < 24 && phase_idx != 4'(t); k++) @(negedge clk);
    endtask

    // One machine cycle, observed tick by tick from tick 1 to tick 0.
    task automatic run_cycle(input bit exp_a, input bit exp_b, input string req);
        align_to(1);
        for (int i = 0; i < 12; i++) begin
            int  t;
            bit  lo;
            t  = (i + 1) % 12;
            lo = (exp_a && (t == 5 || t == 6)) || (exp_b && (t == 10 || t == 11 || t == 0));
            check(phase_idx == 4'(t), "R1 tick order", phase_idx, t);
            check(fetch_rd_n == !lo, req, fetch_rd_n, !lo);
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        do_reset(1'b1);
        fetch_req = 1'b0;
        pc = 16'h8000;
        run_cycle(1'b0, 1'b0, "R2 no fetch stays high");
    endtask

    task automatic t_ext_fetch();
        pc = 16'h4000;
        fetch_req = 1'b1;
        check(code_int_sel == 1'b0, "R6 pc 4000h off-chip", code_int_sel, 0);
        run_cycle(1'b1, 1'b1, "R3 two pulses");
        run_cycle(1'b1, 1'b1, "R6 repeated pulses");
    endtask

    task automatic t_data_cycle();
        align_to(1);
        xdata_cyc = 1'b1;
        run_cycle(1'b0, 1'b0, "R4 data cycle suppresses both");
        xdata_cyc = 1'b0;
        run_cycle(1'b1, 1'b1, "R4 pulses return");
        align_to(7);
        xdata_cyc = 1'b1;
        align_to(11);
        xdata_cyc = 1'b0;
        check(fetch_rd_n == 1'b1, "R4 second window suppressed", fetch_rd_n, 1);
    endtask

    task automatic t_internal();
        pc = 16'h3FFF;
        @(negedge clk);
        check(code_int_sel == 1'b1, "R6 pc 3FFFh on-chip", code_int_sel, 1);
        run_cycle(1'b0, 1'b0, "R5 on-chip no strobe");
        pc = 16'h0123;
        @(negedge clk);
        check(code_int_sel == 1'b1, "R5 low pc on-chip", code_int_sel, 1);
        run_cycle(1'b0, 1'b0, "R5 on-chip no strobe");
    endtask

    task automatic t_ea_low();
        fetch_req = 1'b0;
        do_reset(1'b0);
        pc = 16'h0000;
        fetch_req = 1'b1;
        @(negedge clk);
        check(code_int_sel == 1'b0, "R7 pc 0 off-chip", code_int_sel, 0);
        run_cycle(1'b1, 1'b1, "R7 pulses with ea low");
    endtask

    task automatic t_ea_locked();
        fetch_req = 1'b0;
        do_reset(1'b1);
        ext_code_en = 1'b0;
        pc = 16'h0100;
        fetch_req = 1'b1;
        @(negedge clk);
        check(code_int_sel == 1'b1, "R8 late ea change ignored", code_int_sel, 1);
        run_cycle(1'b0, 1'b0, "R8 still on-chip");
        ext_code_en = 1'b1;
    endtask

    task automatic t_fetch_drop();
        pc = 16'hC000;
        fetch_req = 1'b1;
        align_to(5);
        check(fetch_rd_n == 1'b0, "R9 pulse open", fetch_rd_n, 0);
        fetch_req = 1'b0;
        @(negedge clk);
        check(fetch_rd_n == 1'b1, "R9 drop ends pulse", fetch_rd_n, 1);
        fetch_req = 1'b1;
        run_cycle(1'b1, 1'b1, "R9 pulses resume");
    endtask

    initial begin
        t_reset_state();
        t_ext_fetch();
        t_data_cycle();
        t_internal();
        t_ea_low();
        t_ea_locked();
        t_fetch_drop();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule